// File: doc/BRIEF.md
# I2C Event Handshake Controller

This block sits between the byte-level engine of an I2C peripheral and the software that drives it. The engine reports bus events as one-cycle strobes: a START or repeated START went out, an address or data byte finished (with the acknowledge bit that came back), arbitration was lost, or the peripheral's own address was matched. For each event the controller raises an interrupt flag. One clock later it posts a status code that names the event. While the flag is up, it asks the bus layer to keep SCL low, so the transfer waits until software has dealt with the event.

Software lets the bus continue by writing a one to the flag. The status register carries meaning only while the flag is set. At every other time, and during the first cycle of a newly raised flag, it reads a fixed "nothing to report" code. An event that arrives while the flag is still set is held in a small pending queue and posted once the flag has been cleared. Events that find the queue full are dropped.

Top module: `i2c_hs_ctrl`

## Requirements
- R1: When the flag is clear and any event strobe is high at a rising edge, `irq_flag` is high after that edge.
- R2: On the edge that follows the flag's rise, `status` loads the event's code: START sent 0x08, repeated START sent 0x10.
- R3: `status` reads the idle code 0xF8 whenever `irq_flag` is low, and also in the first cycle after the flag rises.
- R4: `scl_hold_low` is high exactly while `irq_flag` is high.
- R5: Strobes that fall in the same cycle are resolved highest first: arbitration lost, own address match, START, repeated START, address done, data done. Only the winner is posted.
- R6: For address done, `ev_ack_rcvd`=1 gives 0x18 and 0 gives 0x20. For data done, 1 gives 0x28 and 0 gives 0x30.
- R7: Arbitration lost posts 0x38. Own address match posts 0x60.
- R8: A write (`sw_wr_en`=1) with `sw_wr_flag`=1 while the flag is set clears the flag, returns `status` to 0xF8 and drops `scl_hold_low` after that edge. A write with `sw_wr_flag`=0 leaves all outputs unchanged.
- R9: An event that arrives while the flag is set is queued (PEND_DEPTH entries, default 1). The queued event raises the flag on the edge after the clear, with its status code one edge later. An event that arrives while the queue is full is discarded.
- R10: If a clear and an event strobe fall in the same cycle, the clear takes effect and the event is queued. The event then raises the flag one edge later.
- R11: After reset, `irq_flag`=0, `scl_hold_low`=0, `status`=0xF8 and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_start_sent | input | 1 | START transmitted strobe |
| ev_rstart_sent | input | 1 | Repeated START transmitted strobe |
| ev_addr_done | input | 1 | Address byte finished strobe |
| ev_data_done | input | 1 | Data byte finished strobe |
| ev_ack_rcvd | input | 1 | Acknowledge value for address/data strobes (1 = ACK) |
| ev_arb_lost | input | 1 | Arbitration lost strobe |
| ev_own_match | input | 1 | Own address matched strobe |
| sw_wr_en | input | 1 | Software write to the flag |
| sw_wr_flag | input | 1 | Written flag bit; 1 clears the flag |
| irq_flag | output | 1 | Interrupt flag |
| status | output | 8 | Status code, or 0xF8 when nothing to report |
| scl_hold_low | output | 1 | Request to stretch SCL low |

## Verification
The collision that matters is a software clear and a new bus event in the same cycle. Both the clear and the new event then want the flag register and the pending slot at once. The bench provokes this with directed strobes on the exact cycle of a clear-with-one. It also gets the same collision from random clears and strobes that land together. The outcome is judged against a bench model built from R8 to R10: the flag falls, the status goes back to idle, and the flag rises again one edge later with the queued code one edge after that.

// File: rtl/i2c_hs_pkg.sv
package i2c_hs_pkg;

   localparam int unsigned EV_N = 6;

   // strobe index = priority rank, 0 wins
   localparam int unsigned EV_ARB   = 0;
   localparam int unsigned EV_MATCH = 1;
   localparam int unsigned EV_START = 2;
   localparam int unsigned EV_RSTRT = 3;
   localparam int unsigned EV_ADDR  = 4;
   localparam int unsigned EV_DATA  = 5;

   typedef logic [7:0] stat_code_t;

   localparam stat_code_t ST_IDLE      = 8'hF8;
   localparam stat_code_t ST_START     = 8'h08;
   localparam stat_code_t ST_RSTART    = 8'h10;
   localparam stat_code_t ST_ADDR_ACK  = 8'h18;
   localparam stat_code_t ST_ADDR_NACK = 8'h20;
   localparam stat_code_t ST_DATA_ACK  = 8'h28;
   localparam stat_code_t ST_DATA_NACK = 8'h30;
   localparam stat_code_t ST_ARB_LOST  = 8'h38;
   localparam stat_code_t ST_OWN_MATCH = 8'h60;

   typedef struct packed {
      logic       valid;
      stat_code_t code;
   } ev_slot_t;

   function automatic stat_code_t ev_code(input int unsigned idx, input logic ack);
      stat_code_t c;
      case (idx)
         EV_ARB:   c = ST_ARB_LOST;
         EV_MATCH: c = ST_OWN_MATCH;
         EV_START: c = ST_START;
         EV_RSTRT: c = ST_RSTART;
         EV_ADDR:  c = ack ? ST_ADDR_ACK : ST_ADDR_NACK;
         EV_DATA:  c = ack ? ST_DATA_ACK : ST_DATA_NACK;
         default:  c = ST_IDLE;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/i2c_hs_encode.sv
module i2c_hs_encode
   import i2c_hs_pkg::*;
#(
   parameter int unsigned N_EV = EV_N
)(
   input  logic [N_EV-1:0] ev,
   input  logic            ack,
   output ev_slot_t        sel
);

   if (N_EV < 1) begin : g_bad_n
      $error("i2c_hs_encode: N_EV must be at least 1");
   end

   // one-hot of the winning strobe, lowest index first
   logic [N_EV-1:0] win;
   logic [N_EV:0]   seen;

   assign seen[0] = 1'b0;
   for (genvar i = 0; i < N_EV; i++) begin : g_pri
      assign win[i]    = ev[i] & ~seen[i];
      assign seen[i+1] = seen[i] | ev[i];
   end

   always_comb begin
      sel.valid = seen[N_EV];
      sel.code  = ST_IDLE;
      for (int unsigned k = 0; k < N_EV; k++) begin
         if (win[k]) sel.code = ev_code(k, ack);
      end
   end

endmodule

// File: rtl/i2c_hs_queue.sv
module i2c_hs_queue
   import i2c_hs_pkg::*;
#(
   parameter int unsigned DEPTH = 1
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       push,
   input  stat_code_t push_code,
   input  logic       pop,
   output ev_slot_t   head
);

   if (DEPTH > 16) begin : g_bad_depth
      $error("i2c_hs_queue: DEPTH above 16 is not supported");
   end

   if (DEPTH == 0) begin : g_none
      // no storage: anything pushed is dropped
      assign head.valid = 1'b0;
      assign head.code  = ST_IDLE;
   end else begin : g_fifo
      localparam int unsigned PW = (DEPTH < 2) ? 1 : $clog2(DEPTH);
      localparam int unsigned CW = $clog2(DEPTH + 1);
      localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
      localparam logic [CW-1:0] FULL = CW'(DEPTH);

      stat_code_t    mem [DEPTH];
      logic [PW-1:0] rd_q, wr_q;
      logic [CW-1:0] cnt_q;
      logic          do_pop, do_push;

      assign do_pop  = pop && (cnt_q != '0);
      assign do_push = push && ((cnt_q != FULL) || do_pop);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
         end else begin
            if (do_pop)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
            if (do_push) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
            case ({do_push, do_pop})
               2'b10:   cnt_q <= cnt_q + 1'b1;
               2'b01:   cnt_q <= cnt_q - 1'b1;
               default: cnt_q <= cnt_q;
            endcase
         end
      end

      always_ff @(posedge clk) begin
         if (do_push) mem[wr_q] <= push_code;
      end

      assign head.valid = (cnt_q != '0);
      assign head.code  = head.valid ? mem[rd_q] : ST_IDLE;
   end

endmodule

// File: rtl/i2c_hs_seq.sv
module i2c_hs_seq
   import i2c_hs_pkg::*;
#(
   parameter stat_code_t IDLE_CODE = ST_IDLE
)(
   input  logic       clk,
   input  logic       rst_n,
   input  ev_slot_t   src,
   input  logic       clr,
   output logic       flag,
   output stat_code_t stat
);

   logic       flag_q, load_q;
   stat_code_t code_q, stat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         load_q <= 1'b0;
         code_q <= IDLE_CODE;
         stat_q <= IDLE_CODE;
      end else if (flag_q && clr) begin
         flag_q <= 1'b0;
         load_q <= 1'b0;
         stat_q <= IDLE_CODE;
      end else if (!flag_q && src.valid) begin
         flag_q <= 1'b1;
         load_q <= 1'b1;
         code_q <= src.code;
      end else if (load_q) begin
         load_q <= 1'b0;
         stat_q <= code_q;
      end
   end

   assign flag = flag_q;
   assign stat = stat_q;

endmodule

// File: rtl/i2c_hs_ctrl.sv
module i2c_hs_ctrl
   import i2c_hs_pkg::*;
#(
   parameter int unsigned PEND_DEPTH = 1,
   parameter logic [7:0]  IDLE_CODE  = 8'hF8
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ev_start_sent,
   input  logic       ev_rstart_sent,
   input  logic       ev_addr_done,
   input  logic       ev_data_done,
   input  logic       ev_ack_rcvd,
   input  logic       ev_arb_lost,
   input  logic       ev_own_match,
   input  logic       sw_wr_en,
   input  logic       sw_wr_flag,
   output logic       irq_flag,
   output logic [7:0] status,
   output logic       scl_hold_low
);

   logic [EV_N-1:0] ev_vec;
   ev_slot_t        enc, head, src;
   logic            flag, push, pop;
   stat_code_t      stat;

   always_comb begin
      ev_vec           = '0;
      ev_vec[EV_ARB]   = ev_arb_lost;
      ev_vec[EV_MATCH] = ev_own_match;
      ev_vec[EV_START] = ev_start_sent;
      ev_vec[EV_RSTRT] = ev_rstart_sent;
      ev_vec[EV_ADDR]  = ev_addr_done;
      ev_vec[EV_DATA]  = ev_data_done;
   end

   i2c_hs_encode #(.N_EV(EV_N)) u_enc (
      .ev  (ev_vec),
      .ack (ev_ack_rcvd),
      .sel (enc)
   );

   // older queued events go first; a fresh one queues behind them
   assign pop  = !flag && head.valid;
   assign push = enc.valid && (flag || head.valid);

   i2c_hs_queue #(.DEPTH(PEND_DEPTH)) u_q (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .push_code (enc.code),
      .pop       (pop),
      .head      (head)
   );

   always_comb begin
      src.valid = !flag && (head.valid || enc.valid);
      src.code  = head.valid ? head.code : enc.code;
   end

   i2c_hs_seq #(.IDLE_CODE(IDLE_CODE)) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .src   (src),
      .clr   (sw_wr_en && sw_wr_flag),
      .flag  (flag),
      .stat  (stat)
   );

   assign irq_flag     = flag;
   assign status       = stat;
   assign scl_hold_low = flag;

endmodule

// File: rtl/i2c_hs_ctrl_chk.sv
module i2c_hs_ctrl_chk #(
   parameter logic [7:0] IDLE_CODE = 8'hF8
)(
   input logic       clk,
   input logic       rst_n,
   input logic       ev_any,
   input logic       clr_wr,
   input logic       irq_flag,
   input logic [7:0] status,
   input logic       scl_hold_low
);

   a_r1_flag_rises: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_flag && ev_any) |=> irq_flag);

   a_r2_status_posted: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(irq_flag) && !clr_wr) |=> (status != IDLE_CODE));

   a_r3_idle_when_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_flag |-> (status == IDLE_CODE));

   a_r3_idle_first_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_flag) |-> (status == IDLE_CODE));

   a_r4_hold_stays: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flag && !clr_wr) |=> (irq_flag && scl_hold_low));

   a_r8_clear_releases: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flag && clr_wr) |=> (!irq_flag && !scl_hold_low && status == IDLE_CODE));

   a_r8_status_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flag && $past(irq_flag) && !clr_wr) |=> $stable(status));

endmodule

bind i2c_hs_ctrl i2c_hs_ctrl_chk #(.IDLE_CODE(IDLE_CODE)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ev_any       (ev_start_sent | ev_rstart_sent | ev_addr_done | ev_data_done |
                  ev_arb_lost | ev_own_match),
   .clr_wr       (sw_wr_en & sw_wr_flag),
   .irq_flag     (irq_flag),
   .status       (status),
   .scl_hold_low (scl_hold_low)
);

// File: tb/i2c_hs_ctrl_bench.sv
module i2c_hs_ctrl_bench;
   localparam time CLK_PERIOD = 10ns;
   localparam logic [7:0] IDLE = 8'hF8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic e_st, e_rs, e_ad, e_da, e_ack, e_arb, e_m, wr_en, wr_flag;
   logic irq_flag, scl_hold_low;
   logic [7:0] status;

   int n_chk = 0, n_fail = 0;

   // model state
   logic m_flag, m_load, m_qv;
   logic [7:0] m_code, m_stat, m_qc;

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_hs_ctrl u_i2c_hs_ctrl (
      .clk(clk), .rst_n(rst_n),
      .ev_start_sent(e_st), .ev_rstart_sent(e_rs), .ev_addr_done(e_ad),
      .ev_data_done(e_da), .ev_ack_rcvd(e_ack), .ev_arb_lost(e_arb),
      .ev_own_match(e_m), .sw_wr_en(wr_en), .sw_wr_flag(wr_flag),
      .irq_flag(irq_flag), .status(status), .scl_hold_low(scl_hold_low)
   );

   function automatic logic [8:0] enc_exp(input logic st, rs, ad, da, ack, arb, m);
      if (arb) return {1'b1, 8'h38};
      if (m)   return {1'b1, 8'h60};
      if (st)  return {1'b1, 8'h08};
      if (rs)  return {1'b1, 8'h10};
      if (ad)  return {1'b1, ack ? 8'h18 : 8'h20};
      if (da)  return {1'b1, ack ? 8'h28 : 8'h30};
      return {1'b0, IDLE};
   endfunction

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic idle_in();
      {e_st, e_rs, e_ad, e_da, e_ack, e_arb, e_m, wr_en, wr_flag} = '0;
   endtask

   // one clock: model advance at the edge, compare at the following negedge
   task automatic step(input string tag);
      logic [8:0] en;
      logic clr, pop, push, srcv, qv0;
      logic [7:0] srcc;
      @(posedge clk);
      en   = enc_exp(e_st, e_rs, e_ad, e_da, e_ack, e_arb, e_m);
      clr  = wr_en && wr_flag && m_flag;
      pop  = !m_flag && m_qv;
      push = en[8] && (m_flag || m_qv);
      srcv = !m_flag && (m_qv || en[8]);
      srcc = m_qv ? m_qc : en[7:0];
      qv0  = m_qv;
      if (pop) m_qv = 1'b0;
      if (push && (!qv0 || pop)) begin m_qv = 1'b1; m_qc = en[7:0]; end
      if (clr) begin m_flag = 0; m_load = 0; m_stat = IDLE; end
      else if (srcv) begin m_flag = 1; m_load = 1; m_code = srcc; end
      else if (m_load) begin m_load = 0; m_stat = m_code; end
      @(negedge clk);
      chk({tag, " R1 flag"}, {7'd0, irq_flag}, {7'd0, m_flag});
      chk({tag, " R3 status"}, status, m_stat);
      chk({tag, " R4 hold"}, {7'd0, scl_hold_low}, {7'd0, m_flag});
      idle_in();
   endtask

   task automatic clear_flag(input string tag);
      wr_en = 1; wr_flag = 1; step(tag);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 100000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      idle_in();
      m_flag = 0; m_load = 0; m_qv = 0; m_code = IDLE; m_stat = IDLE; m_qc = IDLE;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11 flag", {7'd0, irq_flag}, 8'd0);
      chk("R11 status", status, IDLE);
      chk("R11 hold", {7'd0, scl_hold_low}, 8'd0);
      rst_n = 1;
      @(negedge clk);

      // R1/R2/R3: START, status F8 then 0x08
      e_st = 1; step("R1 start");
      chk("R3 first cycle", status, IDLE);
      step("R2 post");
      chk("R2 start code", status, 8'h08);
      // R8: write of zero ignored
      wr_en = 1; wr_flag = 0; step("R8 zero write");
      chk("R8 zero keeps flag", {7'd0, irq_flag}, 8'd1);
      chk("R8 zero keeps status", status, 8'h08);
      clear_flag("R8 clear");
      chk("R8 cleared status", status, IDLE);

      // R2 repeated start
      e_rs = 1; step("R2 rstart"); step("R2 rstart post");
      chk("R2 rstart code", status, 8'h10);
      clear_flag("R8");

      // R6 ack encodings
      e_ad = 1; e_ack = 0; step("R6 a"); step("R6 a2");
      chk("R6 addr nack", status, 8'h20);
      clear_flag("R8");
      e_da = 1; e_ack = 1; step("R6 d"); step("R6 d2");
      chk("R6 data ack", status, 8'h28);
      clear_flag("R8");

      // R5/R7 priority
      e_arb = 1; e_st = 1; e_m = 1; step("R5 pri"); step("R5 pri2");
      chk("R7 arb wins", status, 8'h38);
      clear_flag("R8");
      e_m = 1; e_da = 1; step("R7 m"); step("R7 m2");
      chk("R7 match code", status, 8'h60);
      clear_flag("R8");

      // R9 queue while set, overflow dropped
      e_st = 1; step("R9 first"); step("R9 first post");
      e_ad = 1; e_ack = 1; step("R9 queued");
      e_da = 1; step("R9 dropped");
      chk("R9 status unchanged", status, 8'h08);
      clear_flag("R9 clear");
      step("R9 requeue rise");
      chk("R9 queued flag", {7'd0, irq_flag}, 8'd1);
      step("R9 queued post");
      chk("R9 queued code", status, 8'h18);
      clear_flag("R9");
      step("R9 empty");
      chk("R9 overflow dropped", {7'd0, irq_flag}, 8'd0);

      // R10 clear and event together
      e_rs = 1; step("R10 a"); step("R10 b");
      wr_en = 1; wr_flag = 1; e_arb = 1; step("R10 collide");
      chk("R10 cleared", {7'd0, irq_flag}, 8'd0);
      step("R10 rise");
      chk("R10 re-raised", {7'd0, irq_flag}, 8'd1);
      step("R10 post");
      chk("R10 code", status, 8'h38);
      clear_flag("R10");

      // random mix
      for (int i = 0; i < 3000; i++) begin
         e_st  = ($urandom_range(0, 9) == 0);
         e_rs  = ($urandom_range(0, 11) == 0);
         e_ad  = ($urandom_range(0, 7) == 0);
         e_da  = ($urandom_range(0, 7) == 0);
         e_arb = ($urandom_range(0, 19) == 0);
         e_m   = ($urandom_range(0, 15) == 0);
         e_ack = 1'($urandom);
         wr_en = ($urandom_range(0, 4) == 0);
         wr_flag = ($urandom_range(0, 3) != 0);
         step("R5 R9 R10 random");
      end

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule